// File: doc/BRIEF.md
# Banked Exception Mask and Execution Priority Unit

This block keeps the exception masking state of a small microcontroller core. There is one copy per security state. Each copy holds an interrupt-off bit, a fault-off bit and a priority floor. From the copy selected by the current security state and a raw execution priority supplied by the exception controller, the block computes the effective execution priority. It then decides whether a pending exception with a given priority may preempt the running code. It also flags when memory accesses must be made with negative-priority permissions.

Software reaches the mask state through a special-register port. The write is clocked and the read is combinational. The port decodes four register numbers. The core reports an exception return as a one-cycle event that carries the return value and the number of the exception being left. On that event the fault-off bit is cleared automatically, except on return from the non-maskable interrupt. When the security extension is built in, the clear is further limited to returns made while the raw priority is non-negative, and it goes to the bank chosen by bit 0 of the return value. Without the extension, only one bank exists and it is the one cleared. Arbitration among exception sources, stacking and memory protection are handled elsewhere.

Top module: `mask_unit`

## Requirements
- R1: After reset every mask copy is 0, so the effective priority equals the raw priority and reads of numbers 16 to 19 return 0.
- R2: With the security extension, reads and writes act only on bank `cur_sec` (0 non-secure, 1 secure). The other bank keeps its value.
- R3: The effective priority is -1 when the active fault-off bit is set. Otherwise it is 0 when the active interrupt-off bit is set. Otherwise it is the active floor when that floor is non-zero and numerically below the raw priority. Otherwise it is the raw priority.
- R4: `take_pend` is 1 exactly when the effective priority is numerically greater (signed) than `pend_prio`.
- R5: A write to number 19 stores only bit 0 of the data into the active fault-off bit. A write to number 16 does the same for the interrupt-off bit. A read of either returns the bit in bit 0 and zeros above it.
- R6: A write to number 17 stores the low PRIO_W bits into the active floor. A read of 17 or 18 returns the active floor zero-extended.
- R7: A write to number 18 changes the floor only when the new value is non-zero and either the floor is 0 or the new value is below it.
- R8: With the security extension, a return from any exception number other than 2 clears the fault-off bit of bank `ret_value[0]` only when `raw_prio` is at least 0. A return from number 2 clears nothing.
- R9: Without the security extension, `cur_sec` is ignored and a single bank exists. A return from any number other than 2 clears its fault-off bit, whatever the raw priority and `ret_value[0]`.
- R10: When a return clear and a number-19 write hit the same bank in the same cycle, the bit ends up 0. A write to the other bank is unaffected.
- R11: `neg_pri_acc` is 1 when `act_exc` is 1, 2 or 3, or when the active fault-off bit is set. Otherwise it is 0.
- R12: Writes to numbers other than 16 to 19 change no state, and reads of them return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cur_sec | input | 1 | Current security state (1 secure) |
| sr_we | input | 1 | Special-register write strobe |
| sr_num | input | 5 | Special-register number |
| sr_wdata | input | 32 | Write data |
| sr_rdata | output | 32 | Read data for `sr_num`, combinational |
| raw_prio | input | PRIO_W+2 | Raw execution priority, signed |
| pend_prio | input | PRIO_W+2 | Priority of the best pending exception, signed |
| ret_valid | input | 1 | Exception-return event, one cycle |
| ret_value | input | 32 | Exception return value, bit 0 selects the bank |
| ret_exc | input | EXC_W | Number of the exception being returned from |
| act_exc | input | EXC_W | Number of the active exception, 0 for thread |
| exec_prio | output | PRIO_W+2 | Effective execution priority, signed |
| take_pend | output | 1 | Pending exception may preempt |
| neg_pri_acc | output | 1 | Negative-priority access permissions apply |

## Verification
The priority function is exercised with each mask alone, with masks stacked so that the precedence order shows, and with the floor placed above, equal to and below the raw priority. Together these separate a correct precedence from a swapped one, and a strict comparison from a non-strict one. The preemption flag is probed with a pending priority just below, equal to and above the effective priority. Exception returns are driven with each value of the bank bit, with negative and zero raw priority, and from the non-maskable interrupt. These cases expose a wrong bank, a missing guard or a missing exemption. A second instance built without the security extension shows the single-bank behaviour.

// File: rtl/mask_pkg.sv
package mask_pkg;
  localparam logic [4:0] SR_IDIS     = 5'd16;
  localparam logic [4:0] SR_FLOOR    = 5'd17;
  localparam logic [4:0] SR_FLOOR_UP = 5'd18;
  localparam logic [4:0] SR_FDIS     = 5'd19;
  localparam int unsigned NMI_NUM    = 2;

  typedef enum logic [1:0] {
    WK_NONE  = 2'd0,
    WK_IDIS  = 2'd1,
    WK_FLOOR = 2'd2,
    WK_FDIS  = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import mask_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              we,
  input  logic [4:0]        num,
  input  logic [31:0]       wdata,
  input  logic [PRIO_W-1:0] floor_cur,
  output wr_kind_e          kind,
  output logic              wbit,
  output logic [PRIO_W-1:0] wfloor
);
  // A raise-only write takes effect when it tightens the floor.
  function automatic logic floor_tightens(input logic [PRIO_W-1:0] cur,
                                          input logic [PRIO_W-1:0] nv);
    return (nv != '0) && ((cur == '0) || (nv < cur));
  endfunction

  assign wbit   = wdata[0];
  assign wfloor = wdata[PRIO_W-1:0];

  always_comb begin
    kind = WK_NONE;
    if (we) begin
      unique case (num)
        SR_IDIS:     kind = WK_IDIS;
        SR_FLOOR:    kind = WK_FLOOR;
        SR_FLOOR_UP: kind = floor_tightens(floor_cur, wfloor) ? WK_FLOOR : WK_NONE;
        SR_FDIS:     kind = WK_FDIS;
        default:     kind = WK_NONE;
      endcase
    end
  end
endmodule

// File: rtl/mask_bank.sv
module mask_bank
  import mask_pkg::*;
#(
  parameter int PRIO_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  wr_kind_e          kind,
  input  logic              wbit,
  input  logic [PRIO_W-1:0] wfloor,
  input  logic              clr_fdis,
  output logic              idis_q,
  output logic              fdis_q,
  output logic [PRIO_W-1:0] floor_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idis_q  <= 1'b0;
      fdis_q  <= 1'b0;
      floor_q <= '0;
    end else begin
      if (kind == WK_IDIS)  idis_q  <= wbit;
      if (kind == WK_FLOOR) floor_q <= wfloor;
      // return clear wins over a same-cycle write
      if (clr_fdis)               fdis_q <= 1'b0;
      else if (kind == WK_FDIS)   fdis_q <= wbit;
    end
  end
endmodule

// File: rtl/prio_resolve.sv
module prio_resolve #(
  parameter int PRIO_W = 8,
  localparam int PW    = PRIO_W + 2
) (
  input  logic                 idis,
  input  logic                 fdis,
  input  logic [PRIO_W-1:0]    floor_v,
  input  logic signed [PW-1:0] raw,
  input  logic signed [PW-1:0] pend,
  output logic signed [PW-1:0] eff,
  output logic                 take
);
  function automatic logic signed [PW-1:0] widen(input logic [PRIO_W-1:0] v);
    return $signed({2'b00, v});
  endfunction

  function automatic logic signed [PW-1:0] effective(
      input logic fd, input logic id, input logic [PRIO_W-1:0] fl,
      input logic signed [PW-1:0] r);
    if (fd)                              return -PW'(1);
    else if (id)                         return '0;
    else if (fl != '0 && widen(fl) < r)  return widen(fl);
    else                                 return r;
  endfunction

  assign eff  = effective(fdis, idis, floor_v, raw);
  assign take = (eff > pend);
endmodule

// File: rtl/mask_unit.sv
module mask_unit
  import mask_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int EXC_W   = 9,
  parameter bit SEC_EXT = 1'b1,
  localparam int PW     = PRIO_W + 2,
  localparam int NBANK  = SEC_EXT ? 2 : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cur_sec,
  input  logic                 sr_we,
  input  logic [4:0]           sr_num,
  input  logic [31:0]          sr_wdata,
  output logic [31:0]          sr_rdata,
  input  logic signed [PW-1:0] raw_prio,
  input  logic signed [PW-1:0] pend_prio,
  input  logic                 ret_valid,
  input  logic [31:0]          ret_value,
  input  logic [EXC_W-1:0]     ret_exc,
  input  logic [EXC_W-1:0]     act_exc,
  output logic signed [PW-1:0] exec_prio,
  output logic                 take_pend,
  output logic                 neg_pri_acc
);
  logic              act_idx;
  logic              clr_fire;
  logic              clr_bank;
  wr_kind_e          dec_kind;
  logic              dec_bit;
  logic [PRIO_W-1:0] dec_floor;
  logic              idis_act;
  logic              fdis_act;
  logic [PRIO_W-1:0] floor_act;
  logic [NBANK-1:0]  idis_bits;
  logic [NBANK-1:0]  fdis_bits;
  logic [PRIO_W-1:0] floor_bits [NBANK];

  // Bank selection and return-clear qualification depend on the variant.
  generate
    if (SEC_EXT) begin : g_sec
      assign act_idx  = cur_sec;
      assign clr_bank = ret_value[0];
      assign clr_fire = ret_valid && (ret_exc != EXC_W'(NMI_NUM)) && (raw_prio >= 0);
    end else begin : g_nosec
      assign act_idx  = 1'b0;
      assign clr_bank = 1'b0;
      assign clr_fire = ret_valid && (ret_exc != EXC_W'(NMI_NUM));
    end
  endgenerate

  assign idis_act  = idis_bits[act_idx];
  assign fdis_act  = fdis_bits[act_idx];
  assign floor_act = floor_bits[act_idx];

  sreg_decode #(.PRIO_W(PRIO_W)) u_dec (
    .we(sr_we), .num(sr_num), .wdata(sr_wdata), .floor_cur(floor_act),
    .kind(dec_kind), .wbit(dec_bit), .wfloor(dec_floor)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    wr_kind_e bk_kind;
    logic     bk_clr;
    assign bk_kind = (act_idx == 1'(b)) ? dec_kind : WK_NONE;
    assign bk_clr  = clr_fire && (clr_bank == 1'(b));
    mask_bank #(.PRIO_W(PRIO_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .kind(bk_kind), .wbit(dec_bit),
      .wfloor(dec_floor), .clr_fdis(bk_clr),
      .idis_q(idis_bits[b]), .fdis_q(fdis_bits[b]), .floor_q(floor_bits[b])
    );
  end

  prio_resolve #(.PRIO_W(PRIO_W)) u_res (
    .idis(idis_act), .fdis(fdis_act), .floor_v(floor_act),
    .raw(raw_prio), .pend(pend_prio), .eff(exec_prio), .take(take_pend)
  );

  always_comb begin
    unique case (sr_num)
      SR_IDIS:              sr_rdata = {31'b0, idis_act};
      SR_FLOOR, SR_FLOOR_UP: sr_rdata = {{(32-PRIO_W){1'b0}}, floor_act};
      SR_FDIS:              sr_rdata = {31'b0, fdis_act};
      default:              sr_rdata = '0;
    endcase
  end

  assign neg_pri_acc = ((act_exc >= EXC_W'(1)) && (act_exc <= EXC_W'(3))) || fdis_act;
endmodule

// File: rtl/mask_unit_chk.sv
module mask_unit_chk #(
  parameter int PRIO_W = 8,
  parameter int EXC_W  = 9,
  parameter int NBANK  = 2,
  localparam int PW    = PRIO_W + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sr_we,
  input logic [4:0]           sr_num,
  input logic [31:0]          sr_wdata,
  input logic signed [PW-1:0] pend_prio,
  input logic signed [PW-1:0] exec_prio,
  input logic                 take_pend,
  input logic                 ret_valid,
  input logic [EXC_W-1:0]     ret_exc,
  input logic [EXC_W-1:0]     act_exc,
  input logic                 neg_pri_acc,
  input logic                 idis_act,
  input logic                 fdis_act,
  input logic [NBANK-1:0]     fdis_bits,
  input logic                 clr_fire,
  input logic                 clr_bank,
  input logic                 act_idx
);
  assert_fault_top_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fdis_act |-> exec_prio == {PW{1'b1}});

  assert_idis_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fdis_act && idis_act) |-> exec_prio == '0);

  assert_take_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_pend |-> (exec_prio > pend_prio));

  assert_clear_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fire |=> !fdis_bits[$past(clr_bank)]);

  assert_nmi_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && ret_exc == EXC_W'(2) && !sr_we) |=> $stable(fdis_bits));

  assert_fdis_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && sr_num == 5'd19 && !(clr_fire && clr_bank == act_idx))
      |=> fdis_bits[$past(act_idx)] == $past(sr_wdata[0]));

  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_we && sr_num == 5'd19 && clr_fire && clr_bank == act_idx)
      |=> !fdis_bits[$past(act_idx)]);

  assert_neg_handler_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (act_exc >= EXC_W'(1) && act_exc <= EXC_W'(3)) |-> neg_pri_acc);
endmodule

bind mask_unit mask_unit_chk #(.PRIO_W(PRIO_W), .EXC_W(EXC_W), .NBANK(NBANK)) u_chk (
  .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_num(sr_num), .sr_wdata(sr_wdata),
  .pend_prio(pend_prio), .exec_prio(exec_prio), .take_pend(take_pend),
  .ret_valid(ret_valid), .ret_exc(ret_exc), .act_exc(act_exc),
  .neg_pri_acc(neg_pri_acc), .idis_act(idis_act), .fdis_act(fdis_act),
  .fdis_bits(fdis_bits), .clr_fire(clr_fire), .clr_bank(clr_bank),
  .act_idx(act_idx)
);

// File: tb/tb_mask_unit.sv
module tb_mask_unit;
  localparam int CLK_PERIOD = 10;
  localparam int PRIO_W = 8;
  localparam int EXC_W  = 9;
  localparam int PW     = PRIO_W + 2;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 cur_sec = 1'b0;
  logic                 sr_we = 1'b0;
  logic [4:0]           sr_num = '0;
  logic [31:0]          sr_wdata = '0;
  logic [31:0]          sr_rdata, sr_rdata0;
  logic signed [PW-1:0] raw_prio = 10'sd256;
  logic signed [PW-1:0] pend_prio = 10'sd256;
  logic                 ret_valid = 1'b0;
  logic [31:0]          ret_value = '0;
  logic [EXC_W-1:0]     ret_exc = '0;
  logic [EXC_W-1:0]     act_exc = '0;
  logic signed [PW-1:0] exec_prio, exec_prio0;
  logic                 take_pend, take_pend0, neg_pri_acc, neg_pri_acc0;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mask_unit #(.PRIO_W(PRIO_W), .EXC_W(EXC_W), .SEC_EXT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .sr_we(sr_we), .sr_num(sr_num),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .raw_prio(raw_prio),
    .pend_prio(pend_prio), .ret_valid(ret_valid), .ret_value(ret_value),
    .ret_exc(ret_exc), .act_exc(act_exc), .exec_prio(exec_prio),
    .take_pend(take_pend), .neg_pri_acc(neg_pri_acc)
  );

  mask_unit #(.PRIO_W(PRIO_W), .EXC_W(EXC_W), .SEC_EXT(1'b0)) dut0 (
    .clk(clk), .rst_n(rst_n), .cur_sec(cur_sec), .sr_we(sr_we), .sr_num(sr_num),
    .sr_wdata(sr_wdata), .sr_rdata(sr_rdata0), .raw_prio(raw_prio),
    .pend_prio(pend_prio), .ret_valid(ret_valid), .ret_value(ret_value),
    .ret_exc(ret_exc), .act_exc(act_exc), .exec_prio(exec_prio0),
    .take_pend(take_pend0), .neg_pri_acc(neg_pri_acc0)
  );

  function automatic int model_prio(input bit fd, input bit id, input int fl, input int r);
    if (fd) return -1;
    if (id) return 0;
    if (fl != 0 && fl < r) return fl;
    return r;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_write(input bit sec, input logic [4:0] num, input logic [31:0] d);
    cur_sec = sec; sr_num = num; sr_wdata = d; sr_we = 1'b1;
    step();
    sr_we = 1'b0;
  endtask

  task automatic rd(input bit sec, input logic [4:0] num, output int v);
    cur_sec = sec; sr_num = num; #1;
    v = int'(sr_rdata);
  endtask

  task automatic do_return(input logic [EXC_W-1:0] exc, input bit es, input int raw);
    raw_prio = PW'(raw); ret_exc = exc; ret_value = {31'h7FFF_FFF8, es}; ret_valid = 1'b1;
    step();
    ret_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sr_we = 1'b0; ret_valid = 1'b0; cur_sec = 1'b0;
    act_exc = '0; raw_prio = 10'sd256; pend_prio = 10'sd256;
    step(); step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_reset();
    int v;
    do_reset();
    #1 check("R1", "exec after reset", int'(exec_prio), 256);
    for (int n = 16; n <= 19; n++) begin
      rd(1'b0, 5'(n), v); check("R1", "ns read after reset", v, 0);
      rd(1'b1, 5'(n), v); check("R1", "s read after reset", v, 0);
    end
  endtask

  task automatic t_bank_fault();
    int v;
    do_reset();
    do_write(1'b1, 5'd19, 32'hFFFF_FFFE);
    rd(1'b1, 5'd19, v); check("R5", "bit0 clear write keeps 0", v, 0);
    do_write(1'b1, 5'd19, 32'h0000_0003);
    rd(1'b1, 5'd19, v); check("R5", "fault bit read", v, 1);
    #1 check("R3", "fault gives -1", int'(exec_prio), -1);
    rd(1'b0, 5'd19, v); check("R2", "other bank untouched", v, 0);
    #1 check("R2", "ns exec equals raw", int'(exec_prio), 256);
  endtask

  task automatic t_prio();
    int v;
    do_reset();
    do_write(1'b0, 5'd16, 32'h5);
    rd(1'b0, 5'd16, v); check("R5", "intr-off read", v, 1);
    do_write(1'b0, 5'd17, 32'h1AB);
    rd(1'b0, 5'd17, v); check("R6", "floor low bits", v, 32'hAB);
    rd(1'b0, 5'd18, v); check("R6", "floor via 18", v, 32'hAB);
    #1 check("R3", "intr-off gives 0", int'(exec_prio), model_prio(0, 1, 'hAB, 256));
    do_write(1'b0, 5'd16, 32'h0);
    raw_prio = 10'sd256; #1
    check("R3", "floor below raw", int'(exec_prio), model_prio(0, 0, 'hAB, 256));
    raw_prio = 10'sd171; #1
    check("R3", "floor equal raw", int'(exec_prio), model_prio(0, 0, 'hAB, 171));
    raw_prio = 10'sd16; #1
    check("R3", "floor above raw", int'(exec_prio), model_prio(0, 0, 'hAB, 16));
    do_write(1'b0, 5'd19, 32'h1);
    do_write(1'b0, 5'd16, 32'h1);
    #1 check("R3", "fault beats intr-off", int'(exec_prio), -1);
    rd(1'b1, 5'd17, v); check("R2", "secure floor untouched", v, 0);
  endtask

  task automatic t_take();
    do_reset();
    raw_prio = 10'sd40;
    pend_prio = 10'sd39; #1 check("R4", "lower pend taken", int'(take_pend), 1);
    pend_prio = 10'sd40; #1 check("R4", "equal pend not taken", int'(take_pend), 0);
    pend_prio = 10'sd41; #1 check("R4", "higher pend not taken", int'(take_pend), 0);
    do_write(1'b0, 5'd19, 32'h1);
    pend_prio = -10'sd2; #1 check("R4", "-2 beats fault", int'(take_pend), 1);
    pend_prio = -10'sd1; #1 check("R4", "-1 blocked by fault", int'(take_pend), 0);
    pend_prio = 10'sd256;
  endtask

  task automatic t_floor_up();
    int v;
    do_reset();
    do_write(1'b1, 5'd18, 32'h50);
    rd(1'b1, 5'd17, v); check("R7", "raise from zero", v, 32'h50);
    do_write(1'b1, 5'd18, 32'h60);
    rd(1'b1, 5'd17, v); check("R7", "looser value ignored", v, 32'h50);
    do_write(1'b1, 5'd18, 32'h20);
    rd(1'b1, 5'd17, v); check("R7", "tighter value taken", v, 32'h20);
    do_write(1'b1, 5'd18, 32'h0);
    rd(1'b1, 5'd17, v); check("R7", "zero ignored", v, 32'h20);
  endtask

  task automatic t_return();
    int v;
    do_reset();
    do_write(1'b0, 5'd19, 32'h1);
    do_write(1'b1, 5'd19, 32'h1);
    do_return(9'd11, 1'b0, 5);
    rd(1'b0, 5'd19, v); check("R8", "ES=0 clears ns", v, 0);
    rd(1'b1, 5'd19, v); check("R8", "ES=0 keeps s", v, 1);
    do_return(9'd11, 1'b1, -1);
    rd(1'b1, 5'd19, v); check("R8", "negative raw no clear", v, 1);
    do_return(9'd2, 1'b1, 5);
    rd(1'b1, 5'd19, v); check("R8", "NMI return no clear", v, 1);
    do_return(9'd3, 1'b1, 0);
    rd(1'b1, 5'd19, v); check("R8", "raw 0 clears s", v, 0);
  endtask

  task automatic t_precedence();
    int v;
    do_reset();
    raw_prio = 10'sd5; ret_exc = 9'd12; ret_value = 32'h0; ret_valid = 1'b1;
    cur_sec = 1'b0; sr_num = 5'd19; sr_wdata = 32'h1; sr_we = 1'b1;
    step(); sr_we = 1'b0; ret_valid = 1'b0;
    rd(1'b0, 5'd19, v); check("R10", "clear wins same bank", v, 0);
    ret_valid = 1'b1; ret_value = 32'h0;
    cur_sec = 1'b1; sr_num = 5'd19; sr_wdata = 32'h1; sr_we = 1'b1;
    step(); sr_we = 1'b0; ret_valid = 1'b0;
    rd(1'b1, 5'd19, v); check("R10", "other bank write kept", v, 1);
  endtask

  task automatic t_neg();
    do_reset();
    act_exc = 9'd1; #1 check("R11", "exc 1", int'(neg_pri_acc), 1);
    act_exc = 9'd3; #1 check("R11", "exc 3", int'(neg_pri_acc), 1);
    act_exc = 9'd4; #1 check("R11", "exc 4", int'(neg_pri_acc), 0);
    act_exc = 9'd0; #1 check("R11", "thread", int'(neg_pri_acc), 0);
    do_write(1'b0, 5'd19, 32'h1);
    #1 check("R11", "fault bit", int'(neg_pri_acc), 1);
    cur_sec = 1'b1; #1 check("R11", "other bank clear", int'(neg_pri_acc), 0);
  endtask

  task automatic t_unknown();
    int v;
    do_reset();
    do_write(1'b0, 5'd20, 32'hFFFF_FFFF);
    do_write(1'b0, 5'd0, 32'hFFFF_FFFF);
    rd(1'b0, 5'd20, v); check("R12", "unknown read", v, 0);
    for (int n = 16; n <= 19; n++) begin
      rd(1'b0, 5'(n), v); check("R12", "no state change", v, 0);
    end
    #1 check("R12", "exec unchanged", int'(exec_prio), 256);
  endtask

  task automatic t_nosec();
    do_reset();
    do_write(1'b1, 5'd19, 32'h1);
    cur_sec = 1'b0; sr_num = 5'd19; #1
    check("R9", "single bank shared", int'(sr_rdata0), 1);
    do_return(9'd11, 1'b1, -1);
    #1 check("R9", "clear despite raw<0 and ES=1", int'(sr_rdata0), 0);
    do_write(1'b0, 5'd19, 32'h1);
    do_return(9'd2, 1'b0, 5);
    #1 check("R9", "NMI return keeps", int'(sr_rdata0), 1);
  endtask

  initial begin
    t_reset();
    t_bank_fault();
    t_prio();
    t_take();
    t_floor_up();
    t_return();
    t_precedence();
    t_neg();
    t_unknown();
    t_nosec();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule